// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Cache

This block sits between a processor-side byte request port and a line-wide main-memory port. Each processor request carries a byte address. The block splits that address into a tag, a set index and a byte offset. Both ways of the indexed set are compared at the same time, and a matching valid line serves the request directly. A processor write changes only the cached copy and marks that line as modified. Main memory is updated later, when a modified line is evicted.

On a miss the block picks a victim way in the set. An empty way is used first. If both ways are full, the way that was used least recently in that set is chosen. A modified victim is sent to memory first. The block then fetches the requested 4-byte line in a single memory beat and replays the request from the cache. Write misses allocate the line before the write is applied. The address width is 24 bits and the set-field width is a parameter. The full-size instance uses a 13-bit set field, which leaves a 9-bit tag. The default parameter value is smaller so that the storage stays compact.

Top module: `c2w_cache`

## Requirements
- R1: Address bits [1:0] select the byte within a line. Bits [SET_W+1:2] select the set, and the remaining upper bits form the tag. Lines with equal tags in different sets are held and looked up independently.
- R2: After reset, every line is invalid, `cpu_ready` is 0 and `mem_req` is 0. The first access to any address after reset is a miss.
- R3: A request hits when either way of its set holds a valid line whose tag equals the address tag. A hit asserts `cpu_ready` for exactly one cycle, in the cycle after the request is first presented, and makes no memory transfer.
- R4: A miss reads the whole line in one memory beat with `mem_addr` equal to address bits [23:2]. Byte offset b of a line sits at bits [8b+7:8b] of the beat. The request is then served from the cache. `mem_req`, `mem_we` and `mem_addr` stay stable until `mem_ack`.
- R5: A processor write that hits updates only the cached byte and marks the line modified. It makes no memory transfer.
- R6: A modified victim is written to memory (`mem_we`=1, `mem_addr` = victim tag and set) before the refill read is issued. A clean victim causes no memory write.
- R7: When both ways of a set are valid, the victim is the way that was not accessed most recently. Each hit and each fill counts as an access.
- R8: A miss fills an invalid way of the set when one exists, and never evicts a valid line in that case.
- R9: A write miss fetches the line first, then writes the byte into the cached copy, which becomes modified.
- R10: A read returns the value most recently written to that byte address. If the byte was never written, it returns the value held in memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Request valid; held with its fields until `cpu_ready` |
| cpu_we | input | 1 | 1 = write byte, 0 = read byte |
| cpu_addr | input | 24 | Byte address |
| cpu_wdata | input | 8 | Write byte |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 8 | Read byte, valid while `cpu_ready` is 1 |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = line write-back, 0 = line read |
| mem_addr | output | 22 | Line (block) address |
| mem_wdata | output | 32 | Line being written back |
| mem_rdata | input | 32 | Line returned, valid with `mem_ack` |
| mem_ack | input | 1 | Completes the current memory beat |

## Verification
A wrong tag, valid or modified bit usually stays hidden until the affected line is touched again. It then appears as an extra or missing memory beat, or as a stale byte. A lost modified bit, for example, only shows when that line is evicted and later read back from memory. For this reason the vectors evict modified lines and then re-read them, so that the data check catches the error within a few accesses. A wrong replacement bit appears on the next miss to the same set, as the wrong write-back address or as an extra write beat. Every access checks the beat counts and addresses, so the error is reported on that same access.

// File: rtl/c2w_pkg.sv
package c2w_pkg;
    localparam int WAYS       = 2;
    localparam int BYTE_W     = 8;
    localparam int LINE_BYTES = 4;
    localparam int OFS_W      = $clog2(LINE_BYTES);
    localparam int LINE_W     = BYTE_W * LINE_BYTES;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RESP  = 2'd1,
        ST_WBACK = 2'd2,
        ST_FILL  = 2'd3
    } ctl_st_e;
endpackage

// File: rtl/c2w_way.sv
module c2w_way
    import c2w_pkg::*;
#(
    parameter int SET_W = 7,
    parameter int TAG_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SET_W-1:0]  set_i,
    output logic [TAG_W-1:0]  tag_o,
    output logic              valid_o,
    output logic              dirty_o,
    output logic [LINE_W-1:0] line_o,
    input  logic              fill_en_i,
    input  logic [TAG_W-1:0]  fill_tag_i,
    input  logic [LINE_W-1:0] fill_line_i,
    input  logic              wr_en_i,
    input  logic [OFS_W-1:0]  wr_ofs_i,
    input  logic [BYTE_W-1:0] wr_byte_i
);
    localparam int SETS = 1 << SET_W;

    logic [SETS-1:0]   valid_q, valid_d;
    logic [SETS-1:0]   dirty_q, dirty_d;
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [LINE_W-1:0] data_q [SETS];

    assign tag_o   = tag_q[set_i];
    assign valid_o = valid_q[set_i];
    assign dirty_o = dirty_q[set_i];
    assign line_o  = data_q[set_i];

    always_comb begin
        valid_d = valid_q;
        dirty_d = dirty_q;
        if (fill_en_i) begin
            valid_d[set_i] = 1'b1;
            dirty_d[set_i] = 1'b0;
        end else if (wr_en_i) begin
            dirty_d[set_i] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else begin
            valid_q <= valid_d;
            dirty_q <= dirty_d;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en_i) begin
            tag_q[set_i]  <= fill_tag_i;
            data_q[set_i] <= fill_line_i;
        end else if (wr_en_i) begin
            data_q[set_i][{wr_ofs_i, 3'b000} +: BYTE_W] <= wr_byte_i;
        end
    end

    // R5
    wr_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |-> valid_q[set_i]);

    // R9
    fill_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fill_en_i && wr_en_i));
endmodule

// File: rtl/c2w_lru.sv
module c2w_lru #(
    parameter int SET_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] set_i,
    input  logic             upd_en_i,
    input  logic             upd_way_i,
    output logic             evict_way_o
);
    localparam int SETS = 1 << SET_W;

    logic [SETS-1:0] evict_q, evict_d;

    assign evict_way_o = evict_q[set_i];

    always_comb begin
        evict_d = evict_q;
        if (upd_en_i) begin
            evict_d[set_i] = ~upd_way_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) evict_q <= '0;
        else        evict_q <= evict_d;
    end
endmodule

// File: rtl/c2w_ctrl.sv
module c2w_ctrl
    import c2w_pkg::*;
#(
    parameter int SET_W = 7,
    parameter int TAG_W = 15
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cpu_req_i,
    input  logic                        cpu_we_i,
    input  logic [TAG_W-1:0]            cpu_tag_i,
    input  logic [SET_W-1:0]            cpu_set_i,
    input  logic [OFS_W-1:0]            cpu_ofs_i,
    input  logic [BYTE_W-1:0]           cpu_wdata_i,
    output logic                        cpu_ready_o,
    output logic [BYTE_W-1:0]           cpu_rdata_o,
    input  logic [WAYS-1:0]             way_valid_i,
    input  logic [WAYS-1:0]             way_dirty_i,
    input  logic [WAYS-1:0][TAG_W-1:0]  way_tag_i,
    input  logic [WAYS-1:0][LINE_W-1:0] way_line_i,
    input  logic                        lru_evict_i,
    output logic                        lru_upd_o,
    output logic                        lru_way_o,
    output logic [WAYS-1:0]             fill_en_o,
    output logic [WAYS-1:0]             wr_en_o,
    output logic                        mem_req_o,
    output logic                        mem_we_o,
    output logic [TAG_W+SET_W-1:0]      mem_addr_o,
    output logic [LINE_W-1:0]           mem_wdata_o,
    input  logic                        mem_ack_i
);
    typedef struct packed {
        ctl_st_e           st;
        logic              vict;
        logic [BYTE_W-1:0] rdata;
    } ctl_reg_t;

    ctl_reg_t        q, d;
    logic [WAYS-1:0] hit;
    logic            hit_way;
    logic            pick_way;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit[w] = way_valid_i[w] && (way_tag_i[w] == cpu_tag_i);
    end

    assign hit_way  = hit[1];
    assign pick_way = !way_valid_i[0] ? 1'b0 :
                      (!way_valid_i[1] ? 1'b1 : lru_evict_i);

    always_comb begin
        d           = q;
        lru_upd_o   = 1'b0;
        lru_way_o   = 1'b0;
        fill_en_o   = '0;
        wr_en_o     = '0;
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        unique case (q.st)
            ST_IDLE: begin
                if (cpu_req_i) begin
                    if (|hit) begin
                        d.st      = ST_RESP;
                        d.rdata   = way_line_i[hit_way][{cpu_ofs_i, 3'b000} +: BYTE_W];
                        lru_upd_o = 1'b1;
                        lru_way_o = hit_way;
                        if (cpu_we_i) wr_en_o[hit_way] = 1'b1;
                    end else begin
                        d.vict = pick_way;
                        d.st   = (way_valid_i[pick_way] && way_dirty_i[pick_way])
                                 ? ST_WBACK : ST_FILL;
                    end
                end
            end
            ST_RESP: begin
                d.st = ST_IDLE;
            end
            ST_WBACK: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = {way_tag_i[q.vict], cpu_set_i};
                mem_wdata_o = way_line_i[q.vict];
                if (mem_ack_i) d.st = ST_FILL;
            end
            ST_FILL: begin
                mem_req_o  = 1'b1;
                mem_addr_o = {cpu_tag_i, cpu_set_i};
                if (mem_ack_i) begin
                    fill_en_o[q.vict] = 1'b1;
                    lru_upd_o         = 1'b1;
                    lru_way_o         = q.vict;
                    d.st              = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{st: ST_IDLE, vict: 1'b0, rdata: '0};
        else        q <= d;
    end

    assign cpu_ready_o = (q.st == ST_RESP);
    assign cpu_rdata_o = q.rdata;

    // R3
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready_o |=> !cpu_ready_o);

    // R3
    hit_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && cpu_req_i) |-> $onehot0(hit));

    // R4
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=>
            (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

    // R6
    wb_dirty_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o) |-> (way_valid_i[q.vict] && way_dirty_i[q.vict]));

    // R6
    wb_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o && mem_ack_i) |=> (mem_req_o && !mem_we_o));

    // R8
    fill_invalid_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|fill_en_o) && !(&way_valid_i)) |-> ((fill_en_o & way_valid_i) == '0));
endmodule

// File: rtl/c2w_cache.sv
module c2w_cache
    import c2w_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int SET_W  = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cpu_req,
    input  logic                    cpu_we,
    input  logic [ADDR_W-1:0]       cpu_addr,
    input  logic [BYTE_W-1:0]       cpu_wdata,
    output logic                    cpu_ready,
    output logic [BYTE_W-1:0]       cpu_rdata,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [ADDR_W-OFS_W-1:0] mem_addr,
    output logic [LINE_W-1:0]       mem_wdata,
    input  logic [LINE_W-1:0]       mem_rdata,
    input  logic                    mem_ack
);
    localparam int TAG_W = ADDR_W - SET_W - OFS_W;

    logic [TAG_W-1:0]             addr_tag;
    logic [SET_W-1:0]             addr_set;
    logic [OFS_W-1:0]             addr_ofs;
    logic [WAYS-1:0]              way_valid;
    logic [WAYS-1:0]              way_dirty;
    logic [WAYS-1:0][TAG_W-1:0]   way_tag;
    logic [WAYS-1:0][LINE_W-1:0]  way_line;
    logic [WAYS-1:0]              fill_en;
    logic [WAYS-1:0]              wr_en;
    logic                         lru_evict;
    logic                         lru_upd;
    logic                         lru_way;

    assign addr_tag = cpu_addr[ADDR_W-1 -: TAG_W];
    assign addr_set = cpu_addr[OFS_W +: SET_W];
    assign addr_ofs = cpu_addr[OFS_W-1:0];

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        c2w_way #(.SET_W(SET_W), .TAG_W(TAG_W)) u_way (
            .clk         (clk),
            .rst_n       (rst_n),
            .set_i       (addr_set),
            .tag_o       (way_tag[w]),
            .valid_o     (way_valid[w]),
            .dirty_o     (way_dirty[w]),
            .line_o      (way_line[w]),
            .fill_en_i   (fill_en[w]),
            .fill_tag_i  (addr_tag),
            .fill_line_i (mem_rdata),
            .wr_en_i     (wr_en[w]),
            .wr_ofs_i    (addr_ofs),
            .wr_byte_i   (cpu_wdata)
        );
    end

    c2w_lru #(.SET_W(SET_W)) u_lru (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_i       (addr_set),
        .upd_en_i    (lru_upd),
        .upd_way_i   (lru_way),
        .evict_way_o (lru_evict)
    );

    c2w_ctrl #(.SET_W(SET_W), .TAG_W(TAG_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_req_i   (cpu_req),
        .cpu_we_i    (cpu_we),
        .cpu_tag_i   (addr_tag),
        .cpu_set_i   (addr_set),
        .cpu_ofs_i   (addr_ofs),
        .cpu_wdata_i (cpu_wdata),
        .cpu_ready_o (cpu_ready),
        .cpu_rdata_o (cpu_rdata),
        .way_valid_i (way_valid),
        .way_dirty_i (way_dirty),
        .way_tag_i   (way_tag),
        .way_line_i  (way_line),
        .lru_evict_i (lru_evict),
        .lru_upd_o   (lru_upd),
        .lru_way_o   (lru_way),
        .fill_en_o   (fill_en),
        .wr_en_o     (wr_en),
        .mem_req_o   (mem_req),
        .mem_we_o    (mem_we),
        .mem_addr_o  (mem_addr),
        .mem_wdata_o (mem_wdata),
        .mem_ack_i   (mem_ack)
    );
endmodule

// File: tb/c2w_cache_tb_top.sv
`timescale 1ns/1ps
module c2w_cache_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [23:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_ready;
    logic [7:0]  cpu_rdata;
    logic        mem_req;
    logic        mem_we;
    logic [21:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;

    int n_chk  = 0;
    int n_fail = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    logic [21:0] last_rd = '0;
    logic [21:0] last_wb = '0;
    bit done = 0;

    logic [31:0] mline  [logic [21:0]];
    logic [7:0]  shadow [logic [23:0]];

    always #2.5 clk = ~clk;

    c2w_cache dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
        .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack)
    );

    function automatic logic [7:0] pat(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h3C;
    endfunction

    function automatic logic [31:0] cur_line(input logic [21:0] b);
        if (mline.exists(b)) return mline[b];
        return {pat({b, 2'd3}), pat({b, 2'd2}), pat({b, 2'd1}), pat({b, 2'd0})};
    endfunction

    function automatic logic [7:0] exp_byte(input logic [23:0] a);
        if (shadow.exists(a)) return shadow[a];
        return pat(a);
    endfunction

    // memory model: one-beat line transfers, ack one cycle after request
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
        end else begin
            mem_ack <= mem_req && !mem_ack;
            if (mem_req && !mem_ack) mem_rdata <= cur_line(mem_addr);
            if (mem_req && mem_ack) begin
                if (mem_we) begin
                    mline[mem_addr] = mem_wdata;
                    wr_cnt++;
                    last_wb = mem_addr;
                end else begin
                    rd_cnt++;
                    last_rd = mem_addr;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [23:0] a, input logic [7:0] wd,
                          input logic exp_rd, input logic exp_wr, input logic [21:0] wbb);
        int  rd0 = rd_cnt;
        int  wr0 = wr_cnt;
        int  cyc = 0;
        bit  got = 0;
        logic [7:0] rdv;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        while (!got && cyc < 60) begin
            @(negedge clk);
            cyc++;
            if (cpu_ready) got = 1;
        end
        rdv = cpu_rdata;
        chk(got, "R3 cpu_ready never seen", 32'(cyc), 32'd6);
        if (!we) chk(rdv == exp_byte(a), "R10/R4 read data", {24'h0, rdv}, {24'h0, exp_byte(a)});
        chk((rd_cnt - rd0) == int'(exp_rd), "R4/R8 memory read beats",
            32'(rd_cnt - rd0), {31'h0, exp_rd});
        chk((wr_cnt - wr0) == int'(exp_wr), "R6/R7/R5 memory write beats",
            32'(wr_cnt - wr0), {31'h0, exp_wr});
        if (!exp_rd && !exp_wr) chk(cyc == 1, "R3 hit latency", 32'(cyc), 32'd1);
        if (exp_rd) chk(last_rd == a[23:2], "R4/R1 refill address", {10'h0, last_rd}, {10'h0, a[23:2]});
        if (exp_wr) chk(last_wb == wbb, "R6/R7 write-back address", {10'h0, last_wb}, {10'h0, wbb});
        if (we) shadow[a] = wd;
        cpu_req = 1'b0; cpu_we = 1'b0;
    endtask

    typedef struct packed {
        logic        we;
        logic [23:0] addr;
        logic [7:0]  wdata;
        logic        rd;
        logic        wr;
        logic [21:0] wbb;
    } vec_t;

    // addresses: tag at [23:9], set at [8:2], byte at [1:0]; set 5 unless noted
    localparam vec_t VECS [16] = '{
        '{1'b0, 24'h000214, 8'h00, 1'b1, 1'b0, 22'h0},     // R2/R8 cold miss -> way0
        '{1'b0, 24'h000217, 8'h00, 1'b0, 1'b0, 22'h0},     // R3 hit, other byte
        '{1'b1, 24'h000216, 8'hC1, 1'b0, 1'b0, 22'h0},     // R5 write hit, no traffic
        '{1'b0, 24'h000415, 8'h00, 1'b1, 1'b0, 22'h0},     // R8 second tag -> empty way1
        '{1'b0, 24'h000216, 8'h00, 1'b0, 1'b0, 22'h0},     // R10 read back cached write
        '{1'b0, 24'h000614, 8'h00, 1'b1, 1'b0, 22'h0},     // R7 evict clean LRU way1
        '{1'b0, 24'h000414, 8'h00, 1'b1, 1'b1, 22'h000085},// R6 evict dirty tag1 line
        '{1'b0, 24'h000216, 8'h00, 1'b1, 1'b0, 22'h0},     // R10 written data via memory
        '{1'b1, 24'h000214, 8'h77, 1'b0, 1'b0, 22'h0},     // R5 write hit
        '{1'b1, 24'h000817, 8'h5E, 1'b1, 1'b0, 22'h0},     // R9 write miss allocates
        '{1'b0, 24'h000817, 8'h00, 1'b0, 1'b0, 22'h0},     // R9 allocated line now hits
        '{1'b0, 24'h000615, 8'h00, 1'b1, 1'b1, 22'h000085},// R7 LRU dirty tag1 evicted
        '{1'b0, 24'h000214, 8'h00, 1'b1, 1'b1, 22'h000205},// R6 dirty tag4 evicted
        '{1'b0, 24'h000817, 8'h00, 1'b1, 1'b0, 22'h0},     // R10 allocated write survived
        '{1'b0, 24'h00021A, 8'h00, 1'b1, 1'b0, 22'h0},     // R1 same tag, set 6 misses
        '{1'b0, 24'h000214, 8'h00, 1'b0, 1'b0, 22'h0}      // R1 set 5 untouched by set 6
    };

    initial begin
        repeat (3) @(negedge clk);
        // R2 outputs idle during reset
        chk(cpu_ready == 1'b0, "R2 cpu_ready in reset", {31'h0, cpu_ready}, 32'h0);
        chk(mem_req == 1'b0, "R2 mem_req in reset", {31'h0, mem_req}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cpu_ready == 1'b0 && mem_req == 1'b0, "R2 idle after reset",
            {30'h0, cpu_ready, mem_req}, 32'h0);

        for (int i = 0; i < 16; i++) begin
            access(VECS[i].we, VECS[i].addr, VECS[i].wdata, VECS[i].rd, VECS[i].wr, VECS[i].wbb);
        end

        // R2 mid-run reset clears valid bits without writing anything back
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(cpu_ready == 1'b0 && mem_req == 1'b0, "R2 idle in second reset",
            {30'h0, cpu_ready, mem_req}, 32'h0);
        rst_n = 1'b1;
        access(1'b0, 24'h000214, 8'h00, 1'b1, 1'b0, 22'h0);  // R2 miss after reset
        access(1'b0, 24'h000214, 8'h00, 1'b0, 1'b0, 22'h0);  // R3 then hit
        // R8 other way of the same set still empty after reset
        access(1'b0, 24'h000A14, 8'h00, 1'b1, 1'b0, 22'h0);
        access(1'b0, 24'h000214, 8'h00, 1'b0, 1'b0, 22'h0);  // R8 first line kept

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R3 watchdog expired actual=%0h expected=%0h", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule